// File: doc/BRIEF.md
# Truncated Signed Multiplier with Radix-8 Digit Recoding

This block multiplies two signed operands of `WIDTH` bits and delivers only the top `WIDTH` bits of the double-width product. It is purely combinational, so the result follows the operands with no clock. The multiplier operand is recoded into signed digits in the range −4..+4, three bits per digit. That gives `ceil(WIDTH/3)` partial-product rows instead of the `WIDTH/2` rows of a two-bit scheme. The only multiple that a shift cannot produce, three times the multiplicand, is built once by one adder and shared by every row.

Each row is formed by selecting one multiple and inverting it when the digit is negative. Only the row bits that fall into the upper `WIDTH` columns of the product enter the adder. Those bits are reduced by a carry-save tree to two vectors, which one carry-propagate adder then sums. The row sign extensions and the expected weight of every discarded low-order bit are folded into a single constant operand. That operand also holds a compensation bias, rounded to the nearest output LSB. The output therefore approximates the product rounded at the output LSB, without the hardware for the lower half.

A typical use is a filter or mixer datapath that keeps a fixed word length from stage to stage, where the lower half of each product would be thrown away anyway.

Top module: `fwb8_mul`

## Requirements
- R1: For the default `WIDTH` of 12, the output read as a signed number differs by at most 2 from the reference `(a*b + 2048) >>> 12`, where a is the multiplicand and b is the multiplier, both signed, and the product is exact.
- R2: The bound of R1 also holds for all four pairings of the extreme operands −2048 and +2047.
- R3: Digit i is recoded from the four multiplier bits 3i+2, 3i+1, 3i and 3i−1, with bit −1 taken as 0 and the multiplier sign-extended to fill the last group. Its value is b[3i−1] + b[3i] + 2·b[3i+1] − 4·b[3i+2].
- R4: Each digit's magnitude selection is one-hot or all zero: bit 0 picks 1X, bit 1 picks 2X, bit 2 picks 3X and bit 3 picks 4X. The negate flag is never set with a zero magnitude, so the groups 0000 and 1111 both give digit 0.
- R5: The shared hard multiple equals exactly three times the sign-extended multiplicand, formed as 2X + X.
- R6: Each row has its sign bit inverted. After that bit is restored and the negate flag is added at the row LSB, the row equals the digit times the multiplicand, modulo 2^(`WIDTH`+3).
- R7: The two carry-save tree outputs sum to the sum of all kept-column operands, modulo 2^`WIDTH`.
- R8: Over a large set of uniformly distributed operand pairs, the mean signed error against the R1 reference stays within ±0.6 LSB.
- R9: With the multiplier equal to zero, the output is exactly the compensation bias for every multiplicand. For `WIDTH` = 12 that bias is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement; recoded into digits |
| prod_hi_o | output | WIDTH | Upper half of the product with bias compensation, two's complement |

## Verification
The bench builds the block with the default `WIDTH` of 12. That gives four digit groups, so the last group's top bit is the multiplier's own sign bit, and it makes the 2-LSB error bound and the bias value of 2 exact, known numbers. At this width every one of the 4096 multiplier values can be swept against fixed multiplicands. That sweep reaches every group code, including 1000 (digit −4) and the 3X selection applied to both extreme multiplicands. A random set of pairs then measures the average error, which exposes a wrong bias constant that the per-vector bound might miss.

// File: rtl/fwb8_pkg.sv
package fwb8_pkg;

   // Decoded radix-8 digit: one-hot magnitude (1X,2X,3X,4X) plus negate flag
   typedef struct packed {
      logic       neg;
      logic [3:0] mag;
   } booth_dig_t;

   // Number of three-bit digit groups covering an n-bit multiplier
   function automatic int num_groups(input int n);
      return (n + 2) / 3;
   endfunction

   // Operand count after lvl rounds of 3:2 compression
   function automatic int csa_count(input int ops, input int lvl);
      int c;
      c = ops;
      for (int k = 0; k < lvl; k++) c = 2 * (c / 3) + (c % 3);
      return c;
   endfunction

   // Rounds of 3:2 compression needed to reach two vectors
   function automatic int csa_levels(input int ops);
      int c;
      int l;
      c = ops;
      l = 0;
      while (c > 2) begin
         c = 2 * (c / 3) + (c % 3);
         l++;
      end
      return l;
   endfunction

   // Bias in output LSBs: each discarded bit counted at half weight, rounded to nearest
   function automatic longint trunc_bias(input int n);
      longint twice_e;
      int     g;
      int     w;
      g = num_groups(n);
      w = n + 3;
      twice_e = 0;
      for (int i = 0; i < g; i++) begin
         for (int j = 0; j < w; j++) begin
            if (3 * i + j < n) twice_e += longint'(1) << (3 * i + j);
         end
         if (3 * i < n) twice_e += longint'(1) << (3 * i);
      end
      return (twice_e + (longint'(1) << n)) >> (n + 1);
   endfunction

   // Constant operand for the kept columns: sign-extension constants plus bias
   function automatic longint kept_const(input int n);
      longint ksum;
      longint mask2;
      longint mask1;
      int     g;
      int     w;
      g = num_groups(n);
      w = n + 3;
      ksum = 0;
      mask2 = (longint'(1) << (2 * n)) - 1;
      mask1 = (longint'(1) << n) - 1;
      for (int i = 0; i < g; i++) begin
         if (w - 1 + 3 * i < 2 * n) ksum += longint'(1) << (w - 1 + 3 * i);
      end
      return ((((((~ksum) + 1) & mask2) >> n) + trunc_bias(n)) & mask1);
   endfunction

endpackage

// File: rtl/fwb8_booth_enc.sv
module fwb8_booth_enc
   import fwb8_pkg::*;
(
   input  logic [3:0] grp_i,
   output booth_dig_t dig_o
);

   always_comb begin
      dig_o = '0;
      unique case (grp_i)
         4'b0000: dig_o = '{neg: 1'b0, mag: 4'b0000};
         4'b0001,
         4'b0010: dig_o = '{neg: 1'b0, mag: 4'b0001};
         4'b0011,
         4'b0100: dig_o = '{neg: 1'b0, mag: 4'b0010};
         4'b0101,
         4'b0110: dig_o = '{neg: 1'b0, mag: 4'b0100};
         4'b0111: dig_o = '{neg: 1'b0, mag: 4'b1000};
         4'b1000: dig_o = '{neg: 1'b1, mag: 4'b1000};
         4'b1001,
         4'b1010: dig_o = '{neg: 1'b1, mag: 4'b0100};
         4'b1011,
         4'b1100: dig_o = '{neg: 1'b1, mag: 4'b0010};
         4'b1101,
         4'b1110: dig_o = '{neg: 1'b1, mag: 4'b0001};
         default: dig_o = '{neg: 1'b0, mag: 4'b0000};
      endcase
   end

endmodule

// File: rtl/fwb8_hard_mult.sv
module fwb8_hard_mult #(
   parameter int W = 15
) (
   input  logic [W-1:0] x_i,
   output logic [W-1:0] x3_o
);

   // Shared 3X: one carry-propagate addition of 2X and X
   assign x3_o = (x_i << 1) + x_i;

endmodule

// File: rtl/fwb8_pp_row.sv
module fwb8_pp_row
   import fwb8_pkg::*;
#(
   parameter int W = 15
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] x3_i,
   input  booth_dig_t   dig_i,
   output logic [W-1:0] row_o
);

   logic [W-1:0] sel;
   logic [W-1:0] inv;

   always_comb begin
      sel = ({W{dig_i.mag[0]}} & x_i)
          | ({W{dig_i.mag[1]}} & (x_i << 1))
          | ({W{dig_i.mag[2]}} & x3_i)
          | ({W{dig_i.mag[3]}} & (x_i << 2));
      // one's complement; the +1 is a separate correction bit at the row LSB
      inv   = sel ^ {W{dig_i.neg}};
      // inverted sign bit: the row's sign extension moves into a constant
      row_o = {~inv[W-1], inv[W-2:0]};
   end

endmodule

// File: rtl/fwb8_csa_tree.sv
module fwb8_csa_tree
   import fwb8_pkg::*;
#(
   parameter int OPS   = 5,
   parameter int WIDTH = 12,
   localparam int LVLS = csa_levels(OPS)
) (
   input  logic [OPS-1:0][WIDTH-1:0] ops_i,
   output logic [WIDTH-1:0]          sum_o,
   output logic [WIDTH-1:0]          carry_o
);

   if (OPS < 3) begin : g_bad_ops
      $error("fwb8_csa_tree needs at least three operands");
   end

   for (genvar l = 0; l < LVLS; l++) begin : g_lvl
      localparam int CNT  = csa_count(OPS, l);
      localparam int TRIP = CNT / 3;
      localparam int REST = CNT - 3 * TRIP;
      localparam int NXT  = 2 * TRIP + REST;

      logic [CNT-1:0][WIDTH-1:0] cur;
      logic [NXT-1:0][WIDTH-1:0] nxt;

      if (l == 0) begin : g_first
         assign cur = ops_i;
      end else begin : g_chain
         assign cur = g_lvl[l-1].nxt;
      end

      for (genvar j = 0; j < TRIP; j++) begin : g_fa
         assign nxt[2*j]   = cur[3*j] ^ cur[3*j+1] ^ cur[3*j+2];
         assign nxt[2*j+1] = ((cur[3*j] & cur[3*j+1])
                            | (cur[3*j] & cur[3*j+2])
                            | (cur[3*j+1] & cur[3*j+2])) << 1;
      end

      for (genvar k = 0; k < REST; k++) begin : g_pass
         assign nxt[2*TRIP+k] = cur[3*TRIP+k];
      end
   end

   assign sum_o   = g_lvl[LVLS-1].nxt[0];
   assign carry_o = g_lvl[LVLS-1].nxt[1];

endmodule

// File: rtl/fwb8_mul.sv
module fwb8_mul
   import fwb8_pkg::*;
#(
   parameter int WIDTH = 12,
   localparam int G    = num_groups(WIDTH),
   localparam int W    = WIDTH + 3,
   localparam int YW   = 3 * G,
   localparam int YEXT = YW - WIDTH,
   localparam int OPS  = G + 1
) (
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic [WIDTH-1:0] prod_hi_o
);

   localparam logic [WIDTH-1:0] CONST_KEPT = WIDTH'(kept_const(WIDTH));

   if (WIDTH < 6 || WIDTH > 28) begin : g_bad_width
      $error("fwb8_mul WIDTH must lie in 6..28");
   end

   logic [W-1:0]               x_ext;
   logic [YW:0]                y_pad;
   logic [G-1:0][3:0]          grp_w;
   booth_dig_t [G-1:0]         dig_w;
   logic [W-1:0]               x3_w;
   logic [G-1:0][W-1:0]        row_w;
   logic [OPS-1:0][WIDTH-1:0]  ops_w;
   logic [WIDTH-1:0]           tsum_w;
   logic [WIDTH-1:0]           tcar_w;

   assign x_ext = {{3{mcand_i[WIDTH-1]}}, mcand_i};

   // multiplier padded with a zero below bit 0 and sign bits above the top
   if (YEXT > 0) begin : g_yext
      assign y_pad = {{YEXT{mplier_i[WIDTH-1]}}, mplier_i, 1'b0};
   end else begin : g_ynoext
      assign y_pad = {mplier_i, 1'b0};
   end

   fwb8_hard_mult #(.W(W)) u_hard (
      .x_i  (x_ext),
      .x3_o (x3_w)
   );

   for (genvar i = 0; i < G; i++) begin : g_row
      assign grp_w[i] = y_pad[3*i+3 -: 4];

      fwb8_booth_enc u_enc (
         .grp_i (grp_w[i]),
         .dig_o (dig_w[i])
      );

      fwb8_pp_row #(.W(W)) u_row (
         .x_i   (x_ext),
         .x3_i  (x3_w),
         .dig_i (dig_w[i]),
         .row_o (row_w[i])
      );

      // only columns WIDTH..2*WIDTH-1 reach the tree; row i starts at column 3i
      for (genvar k = 0; k < WIDTH; k++) begin : g_col
         if (WIDTH + k - 3 * i < W) begin : g_take
            assign ops_w[i][k] = row_w[i][WIDTH+k-3*i];
         end else begin : g_zero
            assign ops_w[i][k] = 1'b0;
         end
      end
   end

   // every negate correction bit sits at column 3i < WIDTH, so it is covered by the bias
   assign ops_w[G] = CONST_KEPT;

   fwb8_csa_tree #(.OPS(OPS), .WIDTH(WIDTH)) u_tree (
      .ops_i   (ops_w),
      .sum_o   (tsum_w),
      .carry_o (tcar_w)
   );

   assign prod_hi_o = tsum_w + tcar_w;

endmodule

// File: rtl/fwb8_mul_chk.sv
module fwb8_mul_chk
   import fwb8_pkg::*;
#(
   parameter int WIDTH = 12,
   localparam int G    = num_groups(WIDTH),
   localparam int W    = WIDTH + 3,
   localparam int OPS  = G + 1
) (
   input logic [WIDTH-1:0]          mcand_i,
   input logic [G-1:0][3:0]         grp_w,
   input booth_dig_t [G-1:0]        dig_w,
   input logic [W-1:0]              x3_w,
   input logic [G-1:0][W-1:0]       row_w,
   input logic [OPS-1:0][WIDTH-1:0] ops_w,
   input logic [WIDTH-1:0]          tsum_w,
   input logic [WIDTH-1:0]          tcar_w
);

   function automatic int grp_value(input logic [3:0] g);
      return int'(g[0]) + int'(g[1]) + 2 * int'(g[2]) - 4 * int'(g[3]);
   endfunction

   function automatic int dig_value(input booth_dig_t d);
      int m;
      m = d.mag[3] ? 4 : d.mag[2] ? 3 : d.mag[1] ? 2 : d.mag[0] ? 1 : 0;
      return d.neg ? -m : m;
   endfunction

   logic [WIDTH-1:0] ops_total;
   logic [W-1:0]     restored;
   int               a_val;

   always_comb begin
      a_val = int'($signed(mcand_i));
      ops_total = '0;
      for (int k = 0; k < OPS; k++) ops_total = ops_total + ops_w[k];

      for (int i = 0; i < G; i++) begin
         // R3
         recode_value_chk: assert (dig_value(dig_w[i]) == grp_value(grp_w[i]))
            else $error("R3 digit %0d mismatch", i);
         // R4
         mag_onehot_chk: assert ($onehot0(dig_w[i].mag) && (dig_w[i].mag != 4'b0000 || !dig_w[i].neg))
            else $error("R4 digit %0d selection invalid", i);
         restored = {~row_w[i][W-1], row_w[i][W-2:0]};
         // R6
         row_value_chk: assert (W'(restored + W'(dig_w[i].neg)) == W'(dig_value(dig_w[i]) * a_val))
            else $error("R6 row %0d value mismatch", i);
      end

      // R5
      hard_mult_chk: assert (x3_w == W'(3 * a_val))
         else $error("R5 hard multiple mismatch");
      // R7
      csa_sum_chk: assert (WIDTH'(tsum_w + tcar_w) == ops_total)
         else $error("R7 carry-save tree sum mismatch");
   end

endmodule

bind fwb8_mul fwb8_mul_chk #(.WIDTH(WIDTH)) u_fwb8_chk (
   .mcand_i (mcand_i),
   .grp_w   (grp_w),
   .dig_w   (dig_w),
   .x3_w    (x3_w),
   .row_w   (row_w),
   .ops_w   (ops_w),
   .tsum_w  (tsum_w),
   .tcar_w  (tcar_w)
);

// File: tb/tb_fwb8_mul.sv
module tb_fwb8_mul;

   localparam int     WIDTH   = 12;
   localparam longint BIAS    = 2;
   localparam longint ERR_MAX = 2;
   localparam int     LIMIT   = 100000;
   localparam int     NRAND   = 16384;
   localparam int     NVEC    = 16;

   // {multiplicand, multiplier}
   localparam logic [23:0] VEC [NVEC] = '{
      {12'h800, 12'h800}, {12'h7FF, 12'h7FF}, {12'h800, 12'h7FF}, {12'h7FF, 12'h800},
      {12'h001, 12'h001}, {12'hFFF, 12'hFFF}, {12'h555, 12'hAAA}, {12'hAAA, 12'h555},
      {12'h123, 12'h456}, {12'hFED, 12'h321}, {12'h400, 12'h400}, {12'hC00, 12'h400},
      {12'h7FF, 12'hFFF}, {12'h800, 12'hFFF}, {12'h3FF, 12'h801}, {12'h9AB, 12'h7CD}
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [WIDTH-1:0] a_r = '0;
   logic [WIDTH-1:0] b_r = '0;
   logic [WIDTH-1:0] p_w;

   int checks = 0;
   int fails  = 0;

   fwb8_mul #(.WIDTH(WIDTH)) dut (
      .mcand_i   (a_r),
      .mplier_i  (b_r),
      .prod_hi_o (p_w)
   );

   function automatic longint ref_hi(input logic [WIDTH-1:0] ai, input logic [WIDTH-1:0] bi);
      longint prod;
      prod = longint'($signed(ai)) * longint'($signed(bi));
      return (prod + 2048) >>> 12;
   endfunction

   task automatic drive(input logic [WIDTH-1:0] ai, input logic [WIDTH-1:0] bi);
      @(posedge clk);
      a_r = ai;
      b_r = bi;
      @(negedge clk);
   endtask

   task automatic chk_near(input logic [WIDTH-1:0] ai, input logic [WIDTH-1:0] bi,
                           input string tag, output longint err);
      longint expv;
      longint got;
      drive(ai, bi);
      expv = ref_hi(ai, bi);
      got  = longint'($signed(p_w));
      err  = got - expv;
      checks++;
      if (err > ERR_MAX || err < -ERR_MAX) begin
         fails++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d+/-%0d",
                  tag, $signed(ai), $signed(bi), got, expv, ERR_MAX);
      end
   endtask

   task automatic chk_exact(input logic [WIDTH-1:0] ai, input logic [WIDTH-1:0] bi,
                            input longint expv, input string tag);
      longint got;
      drive(ai, bi);
      got = longint'($signed(p_w));
      checks++;
      if (got != expv) begin
         fails++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d",
                  tag, $signed(ai), $signed(bi), got, expv);
      end
   endtask

   task automatic run_all;
      longint      err;
      longint      esum;
      logic [31:0] st;

      // initial state with both operands zero: R9
      chk_exact('0, '0, BIAS, "R9");

      // vector table: R1
      for (int v = 0; v < NVEC; v++) begin
         chk_near(VEC[v][23:12], VEC[v][11:0], "R1", err);
      end

      // R2 corner operand pairings
      chk_near(12'h800, 12'h800, "R2", err);
      chk_near(12'h800, 12'h7FF, "R2", err);
      chk_near(12'h7FF, 12'h800, "R2", err);
      chk_near(12'h7FF, 12'h7FF, "R2", err);

      // R9 zero multiplier against several multiplicands
      chk_exact(12'h800, 12'h000, BIAS, "R9");
      chk_exact(12'h7FF, 12'h000, BIAS, "R9");
      chk_exact(12'h5A5, 12'h000, BIAS, "R9");
      chk_exact(12'hFFF, 12'h000, BIAS, "R9");

      // R4 group codes 1111/1110 (b=-1) and 1000 (b=4 gives digit -4 then +1)
      chk_near(12'h7FF, 12'hFFF, "R4", err);
      chk_near(12'h800, 12'hFFF, "R4", err);
      chk_near(12'h7FF, 12'h004, "R4", err);
      chk_near(12'h800, 12'h004, "R4", err);

      // full multiplier sweeps: every group code at each position
      for (int m = 0; m < 4096; m++) chk_near(12'h5A3, 12'(m), "R3", err);
      for (int m = 0; m < 4096; m++) chk_near(12'h7FF, 12'(m), "R5", err);
      for (int m = 0; m < 4096; m++) chk_near(12'h800, 12'(m), "R6", err);

      // random pairs: bound (R7 path through the tree) and mean error (R8)
      st   = 32'h1F2E3D4C;
      esum = 0;
      for (int r = 0; r < NRAND; r++) begin
         st = st ^ (st << 13);
         st = st ^ (st >> 17);
         st = st ^ (st << 5);
         chk_near(st[11:0], st[27:16], "R7", err);
         esum += err;
      end
      checks++;
      if (esum * 5 > longint'(NRAND) * 3 || esum * 5 < -longint'(NRAND) * 3) begin
         fails++;
         $display("FAIL R8 mean error sum actual=%0d expected within +/-%0d",
                  esum, (NRAND * 3) / 5);
      end
   endtask

   initial begin
      fork
         begin
            run_all();
         end
         begin
            repeat (LIMIT) @(posedge clk);
            fails++;
            $display("FAIL R1 watchdog actual=%0d cycles expected=fewer", LIMIT);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule